// File: doc/BRIEF.md
# GPIO Port Data Registers

This block is the data path of one general-purpose I/O port. Software reaches it over a simple word-wide register bus. It programs which pins are outputs, sets the level each output pin drives, and reads back the level seen on every pin. Each pin has one bit in every register.

Besides plain writes to the output latch, the block decodes three write-only action addresses: set, clear and toggle. A 1 in the written word changes the matching latch bit, and a 0 leaves it alone. Software can therefore change a few pins in one bus write, with no read-modify-write sequence and no race against other code that owns the other pins.

Pin levels arrive from the pads asynchronously. They pass through a two-stage synchronizer before software can read them. Pin multiplexing, pull resistors and change detection belong to other blocks.

Top module: `gpio_data_port`

## Requirements
- R1: The direction register (byte offset 0x14) is read/write. Bit n = 1 makes pin n an output, and `pinOe[n]` equals that bit from the cycle after the write.
- R2: The output latch (offset 0x00) is read/write. `pinOut[n]` shows latch bit n when direction bit n is 1 and is 0 otherwise. The latch keeps its value whatever the direction.
- R3: A write to the set address (0x04) forces to 1 every latch bit whose data bit is 1. Other bits keep their value.
- R4: A write to the clear address (0x08) forces to 0 every latch bit whose data bit is 1. Other bits keep their value.
- R5: A write to the toggle address (0x0C) inverts every latch bit whose data bit is 1. Other bits keep their value.
- R6: Reads of the set, clear and toggle addresses return 0.
- R7: A read of the input address (0x10) returns the pin levels through a two-flop synchronizer. A level present before clock edge k can be read after edge k+1. Writes to this address have no effect.
- R8: After reset the direction register, the output latch and the synchronizer hold 0, so every pin is an undriven input.
- R9: Writes to unmapped addresses have no effect. Reads of unmapped addresses return 0, and `busRdData` is 0 whenever `busRdEn` is low.
- R10: Register writes take effect at the clock edge where `busWrEn` is sampled high. Reads are combinational in the same cycle as `busRdEn`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busWrEn | input | 1 | Write strobe |
| busRdEn | input | 1 | Read strobe |
| busAddr | input | ADDR_W | Byte address of the register |
| busWrData | input | PIN_W | Write data |
| busRdData | output | PIN_W | Read data, 0 when not reading |
| pinIn | input | PIN_W | Asynchronous pin levels |
| pinOut | output | PIN_W | Output levels to the pads |
| pinOe | output | PIN_W | Output enables to the pads |

## Verification
The latch is tried with set, clear and toggle words that overlap bits already at 1 and bits already at 0. This shows whether each action touches only the selected bits and whether it forces a level or flips it. Direction masks that cover only part of the port show whether gating of the pad output is kept apart from the stored latch value. Pin levels that change every cycle show the exact two-edge latency of the input path. Writes to the input and unmapped addresses, mixed into a long random stream, show that these writes leave every register unchanged.

// File: rtl/gpio_dp_pkg.sv
package gpio_dp_pkg;

  // Byte offsets of the port registers.
  localparam int unsigned OFS_LATCH = 'h00;
  localparam int unsigned OFS_SET   = 'h04;
  localparam int unsigned OFS_CLR   = 'h08;
  localparam int unsigned OFS_TGL   = 'h0C;
  localparam int unsigned OFS_PINS  = 'h10;
  localparam int unsigned OFS_DIR   = 'h14;

  typedef enum logic [1:0] {
    RD_NONE  = 2'd0,
    RD_LATCH = 2'd1,
    RD_DIR   = 2'd2,
    RD_PINS  = 2'd3
  } rdSel_e;

  typedef struct packed {
    logic   wrLatch;
    logic   wrSet;
    logic   wrClr;
    logic   wrTgl;
    logic   wrDir;
    rdSel_e rdSel;
  } ctlStrobes_t;

endpackage

// File: rtl/gpio_dp_ctrl.sv
module gpio_dp_ctrl
  import gpio_dp_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [ADDR_W-1:0] busAddr,
  output ctlStrobes_t       strobes
);

  localparam logic [ADDR_W-1:0] A_LATCH = ADDR_W'(OFS_LATCH);
  localparam logic [ADDR_W-1:0] A_SET   = ADDR_W'(OFS_SET);
  localparam logic [ADDR_W-1:0] A_CLR   = ADDR_W'(OFS_CLR);
  localparam logic [ADDR_W-1:0] A_TGL   = ADDR_W'(OFS_TGL);
  localparam logic [ADDR_W-1:0] A_PINS  = ADDR_W'(OFS_PINS);
  localparam logic [ADDR_W-1:0] A_DIR   = ADDR_W'(OFS_DIR);

  always_comb begin
    strobes = '0;
    strobes.rdSel = RD_NONE;
    if (busWrEn) begin
      unique case (busAddr)
        A_LATCH: strobes.wrLatch = 1'b1;
        A_SET:   strobes.wrSet   = 1'b1;
        A_CLR:   strobes.wrClr   = 1'b1;
        A_TGL:   strobes.wrTgl   = 1'b1;
        A_DIR:   strobes.wrDir   = 1'b1;
        default: ;
      endcase
    end
    if (busRdEn) begin
      unique case (busAddr)
        A_LATCH: strobes.rdSel = RD_LATCH;
        A_DIR:   strobes.rdSel = RD_DIR;
        A_PINS:  strobes.rdSel = RD_PINS;
        default: strobes.rdSel = RD_NONE;
      endcase
    end
  end

endmodule

// File: rtl/gpio_dp_path.sv
module gpio_dp_path
  import gpio_dp_pkg::*;
#(
  parameter int PIN_W       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctlStrobes_t      strobes,
  input  logic [PIN_W-1:0] wrData,
  input  logic [PIN_W-1:0] pinIn,
  output logic [PIN_W-1:0] rdData,
  output logic [PIN_W-1:0] pinOut,
  output logic [PIN_W-1:0] pinOe
);

  logic [PIN_W-1:0] latchQ, latchNext;
  logic [PIN_W-1:0] dirQ;
  logic [PIN_W-1:0] syncQ [SYNC_STAGES];

  always_comb begin
    latchNext = latchQ;
    if (strobes.wrLatch) latchNext = wrData;
    if (strobes.wrSet)   latchNext = latchQ | wrData;
    if (strobes.wrClr)   latchNext = latchQ & ~wrData;
    if (strobes.wrTgl)   latchNext = latchQ ^ wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      latchQ <= '0;
      dirQ   <= '0;
    end else begin
      latchQ <= latchNext;
      if (strobes.wrDir) dirQ <= wrData;
    end
  end

  genvar s;
  generate
    for (s = 0; s < SYNC_STAGES; s++) begin : g_sync
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)       syncQ[s] <= '0;
        else if (s == 0) syncQ[s] <= pinIn;
        else             syncQ[s] <= syncQ[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  always_comb begin
    unique case (strobes.rdSel)
      RD_LATCH: rdData = latchQ;
      RD_DIR:   rdData = dirQ;
      RD_PINS:  rdData = syncQ[SYNC_STAGES-1];
      default:  rdData = '0;
    endcase
  end

  assign pinOe  = dirQ;
  assign pinOut = latchQ & dirQ;

endmodule

// File: rtl/gpio_data_port.sv
module gpio_data_port
  import gpio_dp_pkg::*;
#(
  parameter int PIN_W  = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [PIN_W-1:0]  busWrData,
  output logic [PIN_W-1:0]  busRdData,
  input  logic [PIN_W-1:0]  pinIn,
  output logic [PIN_W-1:0]  pinOut,
  output logic [PIN_W-1:0]  pinOe
);

  ctlStrobes_t strobes;

  gpio_dp_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .busWrEn (busWrEn),
    .busRdEn (busRdEn),
    .busAddr (busAddr),
    .strobes (strobes)
  );

  gpio_dp_path #(.PIN_W(PIN_W), .SYNC_STAGES(2)) u_path (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .wrData  (busWrData),
    .pinIn   (pinIn),
    .rdData  (busRdData),
    .pinOut  (pinOut),
    .pinOe   (pinOe)
  );

endmodule

// File: rtl/gpio_data_port_checker.sv
module gpio_data_port_checker
  import gpio_dp_pkg::*;
#(
  parameter int PIN_W  = 32,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              busWrEn,
  input logic              busRdEn,
  input logic [ADDR_W-1:0] busAddr,
  input logic [PIN_W-1:0]  busWrData,
  input logic [PIN_W-1:0]  busRdData,
  input logic [PIN_W-1:0]  pinIn,
  input logic [PIN_W-1:0]  pinOut,
  input logic [PIN_W-1:0]  pinOe
);

  logic hitSet, hitClr, hitTgl, hitDir, hitWo;
  assign hitSet = busWrEn && (busAddr == ADDR_W'(OFS_SET));
  assign hitClr = busWrEn && (busAddr == ADDR_W'(OFS_CLR));
  assign hitTgl = busWrEn && (busAddr == ADDR_W'(OFS_TGL));
  assign hitDir = busWrEn && (busAddr == ADDR_W'(OFS_DIR));
  assign hitWo  = busRdEn && ((busAddr == ADDR_W'(OFS_SET)) ||
                  (busAddr == ADDR_W'(OFS_CLR)) || (busAddr == ADDR_W'(OFS_TGL)));

  assert_dir_hold_R1: assert property (@(posedge clk) disable iff (!rstN)
    !hitDir |=> $stable(pinOe));

  assert_gate_R2: assert property (@(posedge clk) disable iff (!rstN)
    (pinOut & ~pinOe) == '0);

  assert_set_R3: assert property (@(posedge clk) disable iff (!rstN)
    hitSet |=> ((pinOut & $past(busWrData) & pinOe) == ($past(busWrData) & pinOe)));

  assert_clear_R4: assert property (@(posedge clk) disable iff (!rstN)
    hitClr |=> ((pinOut & $past(busWrData)) == '0));

  assert_toggle_R5: assert property (@(posedge clk) disable iff (!rstN)
    hitTgl |=> (((pinOut ^ $past(pinOut)) & pinOe) == ($past(busWrData) & pinOe)));

  assert_wo_zero_R6: assert property (@(posedge clk) disable iff (!rstN)
    hitWo |-> (busRdData == '0));

  assert_idle_zero_R9: assert property (@(posedge clk) disable iff (!rstN)
    !busRdEn |-> (busRdData == '0));

endmodule

bind gpio_data_port gpio_data_port_checker #(.PIN_W(PIN_W), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .busWrEn   (busWrEn),
  .busRdEn   (busRdEn),
  .busAddr   (busAddr),
  .busWrData (busWrData),
  .busRdData (busRdData),
  .pinIn     (pinIn),
  .pinOut    (pinOut),
  .pinOe     (pinOe)
);

// File: tb/test_gpio_data_port.sv
`timescale 1ns/1ps
module test_gpio_data_port;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWrEn = 1'b0;
  logic        busRdEn = 1'b0;
  logic [7:0]  busAddr = '0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic [31:0] pinIn = '0;
  logic [31:0] pinOut;
  logic [31:0] pinOe;

  int errors = 0;
  int checks = 0;
  bit primed = 0;
  bit done = 0;

  always #2 clk = ~clk;

  gpio_data_port i_gpio_data_port (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busRdEn(busRdEn),
    .busAddr(busAddr), .busWrData(busWrData), .busRdData(busRdData),
    .pinIn(pinIn), .pinOut(pinOut), .pinOe(pinOe)
  );

  // Behavioural reference model
  logic [31:0] mLatch, mDir;
  logic [31:0] pinHist[$];

  always @(posedge clk) begin
    primed <= 1'b1;
    if (!rstN) begin
      mLatch = '0;
      mDir = '0;
      pinHist = {32'd0, 32'd0};
    end else begin
      if (busWrEn) begin
        case (busAddr)
          8'h00: mLatch = busWrData;
          8'h04: mLatch = mLatch | busWrData;
          8'h08: mLatch = mLatch & ~busWrData;
          8'h0C: mLatch = mLatch ^ busWrData;
          8'h14: mDir = busWrData;
          default: ;
        endcase
      end
      pinHist.push_back(pinIn);
      void'(pinHist.pop_front());
    end
  end

  function automatic logic [31:0] expRead();
    if (!busRdEn) return '0;
    case (busAddr)
      8'h00: return mLatch;
      8'h10: return pinHist[0];
      8'h14: return mDir;
      default: return '0;
    endcase
  endfunction

  function automatic string readTag();
    if (!busRdEn) return "R9";
    case (busAddr)
      8'h00: return "R2";
      8'h04, 8'h08, 8'h0C: return "R6";
      8'h10: return "R7";
      8'h14: return "R1";
      default: return "R9";
    endcase
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (primed && !done) begin
      check("R1 pinOe", pinOe, mDir);
      check("R2 pinOut", pinOut, mLatch & mDir);
      check({readTag(), " rdData"}, busRdData, expRead());
    end
  end

  task automatic busOp(bit we, bit re, logic [7:0] a, logic [31:0] d);
    @(negedge clk); #1;
    busWrEn = we; busRdEn = re; busAddr = a; busWrData = d;
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    busOp(1, 0, a, d);
  endtask

  task automatic rd(logic [7:0] a);
    busOp(0, 1, a, '0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R8: reset state seen at the ports
    check("R8 pinOe reset", pinOe, 32'h0);
    check("R8 pinOut reset", pinOut, 32'h0);
    #1 rstN = 1'b1;
    rd(8'h00); rd(8'h14); rd(8'h10);
    // R1 and R2: partial direction mask, latch keeps hidden bits
    wr(8'h14, 32'hFFFF_0000);
    wr(8'h00, 32'hA5A5_A5A5);
    rd(8'h00);
    // R3, R4, R5 with overlapping masks
    wr(8'h04, 32'h0F0F_00FF);
    rd(8'h00);
    wr(8'h08, 32'hFF00_000F);
    rd(8'h00);
    wr(8'h0C, 32'h3C3C_3C3C);
    wr(8'h0C, 32'h3C3C_3C3C);
    rd(8'h00);
    wr(8'h14, 32'hFFFF_FFFF);
    wr(8'h0C, 32'hFFFF_FFFF);
    // R6: write-only addresses read 0
    rd(8'h04); rd(8'h08); rd(8'h0C);
    // R7: writes to input address ignored; latency
    wr(8'h10, 32'hDEAD_BEEF);
    rd(8'h00);
    busOp(0, 1, 8'h10, '0);
    pinIn = 32'h1234_5678;
    repeat (3) @(negedge clk);
    #1 pinIn = 32'h8765_4321;
    repeat (3) @(negedge clk);
    // R9: unmapped addresses
    wr(8'h18, 32'hFFFF_FFFF);
    wr(8'h02, 32'hFFFF_FFFF);
    rd(8'h18); rd(8'h00); rd(8'h14);
    // R10: back-to-back random stream
    for (int i = 0; i < 2000; i++) begin
      int op;
      logic [7:0] a;
      op = $urandom_range(0, 7);
      a = (op == 7) ? 8'($urandom_range(0, 255)) : 8'(op * 4);
      busOp($urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1, a, $urandom());
      if ($urandom_range(0, 3) == 0) pinIn = $urandom();
    end
    busOp(0, 0, 8'h00, '0);
    repeat (3) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL R10 watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule